// File: doc/BRIEF.md
# Multiplexed Address/Data I/O Port

This block is a pair of 8-bit ports for a small microcontroller. The low port has two uses. It can be an open-drain general-purpose port driven from its own output latch. It can also be the multiplexed low address/data bus during an external memory access. A companion high port drives the upper address byte during external accesses and is otherwise an I/O port driven from its own latch.

The block does not drive pads directly. For every pin it produces a separate drive-low enable and drive-high enable. The pad tri-state, the external pull-ups and any outside logic live outside the block. When both enables of a pin are off, the pin floats. It then reads high through a pull-up, or low when outside logic holds it low.

The CPU writes either latch with a write strobe and the shared 8-bit data bus. One read port returns one of four sources, chosen by a 2-bit select: the sampled pin levels or the latch contents, of either port. A single control input, `ext_mode`, switches both ports into the external-access behaviour.

Top module: `adport_top`

## Requirements
- R1: A synchronous reset sets both latches to 0xFF. With `ext_mode` low, every drive enable is then 0 and every pin floats.
- R2: With `ext_mode` low, `lo_drv_high` is all zeros. Bit i of `lo_drv_low` is 1 exactly when bit i of the low latch is 0.
- R3: When a write strobe (`wr_lo` or `wr_hi`) is high at a clock edge, `wr_data` is stored into that latch at that edge. For the low latch this holds only when `ext_mode` is low. A latch read shows the new value from the following cycle.
- R4: A pin read returns the sampled pad levels, not the latch. A pin whose latch bit is 1 reads 0 while outside logic holds it low, so the pin read and the latch read then differ.
- R5: With `ext_mode` high, each low-port pin follows `ad_lo` push-pull. A 1 sets `lo_drv_high` and clears `lo_drv_low`, and a 0 does the opposite.
- R6: At every clock edge where `ext_mode` is high, the low latch is loaded with 0xFF and a simultaneous `wr_lo` is ignored. After `ext_mode` falls, all low-port pins float.
- R7: With `ext_mode` high, the high port drives `addr_hi` push-pull. The high latch is not changed by the access, and its earlier value drives the pins again once `ext_mode` falls.
- R8: With `ext_mode` low, `hi_drv_high` is all zeros. Bit i of `hi_drv_low` is 1 exactly when bit i of the high latch is 0.
- R9: On every pin of both ports, the drive-low and drive-high enables are never 1 in the same cycle.
- R10: `rd_src` selects the read source: 0 gives the low pins, 1 the low latch, 2 the high pins, 3 the high latch. `rd_data` is the selected value while `rd_en` is 1 and 0x00 while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 during an external memory access |
| wr_lo | input | 1 | Write strobe for the low-port latch |
| wr_hi | input | 1 | Write strobe for the high-port latch |
| wr_data | input | 8 | CPU write data |
| ad_lo | input | 8 | Internal low address/data byte |
| addr_hi | input | 8 | Internal upper address byte |
| pin_lo_in | input | 8 | Sampled low-port pad levels |
| pin_hi_in | input | 8 | Sampled high-port pad levels |
| rd_en | input | 1 | Read strobe |
| rd_src | input | 2 | Read source select |
| rd_data | output | 8 | Read result |
| lo_drv_low | output | 8 | Low-port pull-down enables |
| lo_drv_high | output | 8 | Low-port pull-up enables |
| hi_drv_low | output | 8 | High-port pull-down enables |
| hi_drv_high | output | 8 | High-port pull-up enables |

## Verification
Several rules are checked by assertions on every cycle:
- the absence of driver contention on every pin;
- that the low port's upper drivers stay off in I/O mode;
- that the low-port pins follow `ad_lo` in external mode;
- that the low latch is forced to all ones by an access;
- that a write lands in the low latch, and that the high latch holds through an access.

Other behaviour can only be shown by the bench's scenarios, which model the pads with pull-ups and outside pull-down masks. These cover:
- the difference between a pin read and a latch read;
- the return of the high port to its latch value after an access;
- the read source encoding and the zero result when no read is requested.

// File: rtl/adport_pkg.sv
package adport_pkg;
    localparam int PORT_W = 8;
    localparam logic [PORT_W-1:0] LATCH_RST = '1;

    typedef enum logic [1:0] {
        SRC_LO_PIN = 2'd0,
        SRC_LO_LAT = 2'd1,
        SRC_HI_PIN = 2'd2,
        SRC_HI_LAT = 2'd3
    } rd_src_e;

    typedef struct packed {
        logic [PORT_W-1:0] pull_dn;
        logic [PORT_W-1:0] push_up;
    } pad_drv_t;

    // per-pin driver decision: open-drain from latch, or push-pull from bus
    function automatic logic [1:0] pin_drive(input logic ext_sel, input logic lat_bit,
                                             input logic bus_bit);
        logic [1:0] r; // {pull_dn, push_up}
        if (ext_sel) r = {~bus_bit, bus_bit};
        else         r = {~lat_bit, 1'b0};
        return r;
    endfunction
endpackage

// File: rtl/adport_latch.sv
module adport_latch
    import adport_pkg::*;
#(
    parameter int W = PORT_W,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_all,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= RST_VAL;
        else if (set_all) q <= '1;
        else if (wr_en)   q <= wr_data;
    end
endmodule

// File: rtl/adport_drv.sv
module adport_drv
    import adport_pkg::*;
(
    input  logic              ext_sel,
    input  logic [PORT_W-1:0] lat,
    input  logic [PORT_W-1:0] bus,
    output pad_drv_t          drv
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        logic [1:0] d;
        always_comb d = pin_drive(ext_sel, lat[i], bus[i]);
        assign drv.pull_dn[i] = d[1];
        assign drv.push_up[i] = d[0];
    end
endmodule

// File: rtl/adport_rdmux.sv
module adport_rdmux
    import adport_pkg::*;
(
    input  logic              en,
    input  logic [1:0]        src,
    input  logic [PORT_W-1:0] lo_pin,
    input  logic [PORT_W-1:0] lo_lat,
    input  logic [PORT_W-1:0] hi_pin,
    input  logic [PORT_W-1:0] hi_lat,
    output logic [PORT_W-1:0] dout
);
    rd_src_e sel;
    always_comb begin
        sel  = rd_src_e'(src);
        dout = '0;
        if (en) begin
            unique case (sel)
                SRC_LO_PIN: dout = lo_pin;
                SRC_LO_LAT: dout = lo_lat;
                SRC_HI_PIN: dout = hi_pin;
                SRC_HI_LAT: dout = hi_lat;
                default:    dout = '0;
            endcase
        end
    end
endmodule

// File: rtl/adport_top.sv
module adport_top
    import adport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_mode,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [PORT_W-1:0] wr_data,
    input  logic [PORT_W-1:0] ad_lo,
    input  logic [PORT_W-1:0] addr_hi,
    input  logic [PORT_W-1:0] pin_lo_in,
    input  logic [PORT_W-1:0] pin_hi_in,
    input  logic              rd_en,
    input  logic [1:0]        rd_src,
    output logic [PORT_W-1:0] rd_data,
    output logic [PORT_W-1:0] lo_drv_low,
    output logic [PORT_W-1:0] lo_drv_high,
    output logic [PORT_W-1:0] hi_drv_low,
    output logic [PORT_W-1:0] hi_drv_high
);
    logic [PORT_W-1:0] lat_lo, lat_hi;
    pad_drv_t          drv_lo, drv_hi;

    // low latch: an external access loads all ones
    adport_latch #(.W(PORT_W), .RST_VAL(LATCH_RST)) u_lat_lo (
        .clk(clk), .rst(rst), .set_all(ext_mode), .wr_en(wr_lo),
        .wr_data(wr_data), .q(lat_lo)
    );

    // high latch: untouched by external accesses
    adport_latch #(.W(PORT_W), .RST_VAL(LATCH_RST)) u_lat_hi (
        .clk(clk), .rst(rst), .set_all(1'b0), .wr_en(wr_hi),
        .wr_data(wr_data), .q(lat_hi)
    );

    adport_drv u_drv_lo (.ext_sel(ext_mode), .lat(lat_lo), .bus(ad_lo),   .drv(drv_lo));
    adport_drv u_drv_hi (.ext_sel(ext_mode), .lat(lat_hi), .bus(addr_hi), .drv(drv_hi));

    adport_rdmux u_rd (
        .en(rd_en), .src(rd_src),
        .lo_pin(pin_lo_in), .lo_lat(lat_lo),
        .hi_pin(pin_hi_in), .hi_lat(lat_hi),
        .dout(rd_data)
    );

    assign lo_drv_low  = drv_lo.pull_dn;
    assign lo_drv_high = drv_lo.push_up;
    assign hi_drv_low  = drv_hi.pull_dn;
    assign hi_drv_high = drv_hi.push_up;
endmodule

// File: rtl/adport_chk.sv
module adport_chk
    import adport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ext_mode,
    input logic              wr_lo,
    input logic              wr_hi,
    input logic [PORT_W-1:0] wr_data,
    input logic [PORT_W-1:0] ad_lo,
    input logic [PORT_W-1:0] lat_lo,
    input logic [PORT_W-1:0] lat_hi,
    input logic [PORT_W-1:0] lo_drv_low,
    input logic [PORT_W-1:0] lo_drv_high,
    input logic [PORT_W-1:0] hi_drv_low,
    input logic [PORT_W-1:0] hi_drv_high
);
    // R9
    lo_no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_drv_low & lo_drv_high) == '0);
    // R9
    hi_no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_drv_low & hi_drv_high) == '0);
    // R2
    io_no_push_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_mode |-> lo_drv_high == '0);
    // R5
    ext_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ext_mode |-> (lo_drv_high == ad_lo) && (lo_drv_low == ~ad_lo));
    // R6
    ext_latch_set_chk: assert property (@(posedge clk) disable iff (rst)
        ext_mode |=> lat_lo == '1);
    // R3
    lo_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && wr_lo) |=> lat_lo == $past(wr_data));
    // R7
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && !wr_hi) |=> $stable(lat_hi));
endmodule

bind adport_top adport_chk u_chk (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .ad_lo(ad_lo), .lat_lo(lat_lo), .lat_hi(lat_hi),
    .lo_drv_low(lo_drv_low), .lo_drv_high(lo_drv_high),
    .hi_drv_low(hi_drv_low), .hi_drv_high(hi_drv_high)
);

// File: tb/sim_adport_top.sv
`timescale 1ns/1ps
module sim_adport_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_mode = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0, ad_lo = '0, addr_hi = '0;
    logic [1:0] rd_src = '0;
    logic [7:0] ext_lo_dn = '0, ext_hi_dn = '0;   // outside logic holding pins low
    logic [7:0] pin_lo_in, pin_hi_in, rd_data;
    logic [7:0] lo_drv_low, lo_drv_high, hi_drv_low, hi_drv_high;

    always #10 clk = ~clk;   // 50 MHz

    // pad model: strong drivers win, otherwise outside pull-down, otherwise pull-up
    for (genvar i = 0; i < 8; i++) begin : g_pad
        assign pin_lo_in[i] = lo_drv_low[i] ? 1'b0 : lo_drv_high[i] ? 1'b1 : ~ext_lo_dn[i];
        assign pin_hi_in[i] = hi_drv_low[i] ? 1'b0 : hi_drv_high[i] ? 1'b1 : ~ext_hi_dn[i];
    end

    adport_top u0 (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .ad_lo(ad_lo), .addr_hi(addr_hi),
        .pin_lo_in(pin_lo_in), .pin_hi_in(pin_hi_in), .rd_en(rd_en), .rd_src(rd_src),
        .rd_data(rd_data), .lo_drv_low(lo_drv_low), .lo_drv_high(lo_drv_high),
        .hi_drv_low(hi_drv_low), .hi_drv_high(hi_drv_high)
    );

    typedef struct {
        int         cyc;
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] m_lo = 8'hFF, m_hi = 8'hFF;   // bench model of the latches

    function automatic logic [7:0] observe(int sel);
        case (sel)
            0: return rd_data;
            1: return lo_drv_low;
            2: return lo_drv_high;
            3: return hi_drv_low;
            4: return hi_drv_high;
            5: return lo_drv_low & lo_drv_high;
            default: return hi_drv_low & hi_drv_high;
        endcase
    endfunction

    function automatic void push(int sel, logic [7:0] exp, string tag);
        item_t it;
        it.cyc = cyc; it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endfunction

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc == cyc) begin
            item_t it;
            logic [7:0] act;
            it  = sb.pop_front();
            act = observe(it.sel);
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    // driver: one clock cycle of stimulus plus expectations from the model
    task automatic step(input logic ext, input logic wl, input logic wh, input logic [7:0] wd,
                        input logic [7:0] ad, input logic [7:0] ah, input logic re,
                        input logic [1:0] rs, input logic [7:0] dlo, input logic [7:0] dhi,
                        input string rtag);
        logic [7:0] e_lo_dn, e_lo_up, e_hi_dn, e_hi_up, p_lo, p_hi, e_rd;
        @(posedge clk); #1;
        cyc++;
        ext_mode = ext; wr_lo = wl; wr_hi = wh; wr_data = wd; ad_lo = ad; addr_hi = ah;
        rd_en = re; rd_src = rs; ext_lo_dn = dlo; ext_hi_dn = dhi;
        e_lo_up = ext ? ad : 8'h00;
        e_lo_dn = ext ? ~ad : ~m_lo;
        e_hi_up = ext ? ah : 8'h00;
        e_hi_dn = ext ? ~ah : ~m_hi;
        p_lo = ~e_lo_dn & (e_lo_up | ~dlo);
        p_hi = ~e_hi_dn & (e_hi_up | ~dhi);
        case (rs)
            2'd0: e_rd = p_lo;
            2'd1: e_rd = m_lo;
            2'd2: e_rd = p_hi;
            default: e_rd = m_hi;
        endcase
        if (!re) e_rd = 8'h00;
        push(0, e_rd, rtag);
        push(1, e_lo_dn, ext ? "R5" : "R2");
        push(2, e_lo_up, ext ? "R5" : "R2");
        push(3, e_hi_dn, ext ? "R7" : "R8");
        push(4, e_hi_up, ext ? "R7" : "R8");
        push(5, 8'h00, "R9");
        push(6, 8'h00, "R9");
        // model update at the coming edge
        if (ext)     m_lo = 8'hFF;
        else if (wl) m_lo = wd;
        if (wh)      m_hi = wd;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state, latch reads FF, drivers off
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, 2'd1, 8'h00, 8'h00, "R1");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, 2'd3, 8'h00, 8'h00, "R1");
        // R3: write low latch, pins still float this cycle (R4)
        step(0, 1, 0, 8'hA5, 8'h00, 8'h00, 1, 2'd0, 8'h00, 8'h00, "R4");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, 2'd1, 8'h00, 8'h00, "R3");
        // R4: outside logic pulls bits 0 and 7 low
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, 2'd0, 8'h81, 8'h00, "R4");
        step(0, 1, 0, 8'hFF, 8'h00, 8'h00, 1, 2'd1, 8'h00, 8'h00, "R3");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, 2'd0, 8'h3C, 8'h00, "R4");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, 2'd1, 8'h3C, 8'h00, "R4");
        // R3/R8: high latch write, then I/O drive of the high port
        step(0, 0, 1, 8'h0F, 8'h00, 8'h00, 1, 2'd3, 8'h00, 8'h00, "R3");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, 2'd3, 8'h00, 8'h00, "R3");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, 2'd2, 8'h00, 8'h00, "R8");
        // R5/R6: external access, low write during it ignored
        step(1, 1, 0, 8'h00, 8'h96, 8'h12, 1, 2'd0, 8'h00, 8'h00, "R5");
        step(1, 0, 0, 8'h00, 8'h69, 8'h34, 1, 2'd2, 8'h00, 8'h00, "R7");
        step(1, 0, 0, 8'h00, 8'h3C, 8'hC3, 1, 2'd3, 8'h00, 8'h00, "R7");
        // R6: access ended, low latch all ones and pins float
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, 2'd1, 8'h00, 8'h00, "R6");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, 2'd0, 8'h00, 8'h00, "R6");
        // R7: high port back to its latch value
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 1, 2'd2, 8'h00, 8'h00, "R7");
        // R10: no read requested
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 0, 2'd3, 8'h00, 8'h00, "R10");
        step(0, 0, 0, 8'h00, 8'h00, 8'h00, 0, 2'd0, 8'h00, 8'h00, "R10");
        @(posedge clk); @(negedge clk); #1;
        if (sb.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard actual=%0d expected=0 items left", sb.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule